// File: doc/BRIEF.md
# H-Bridge Gate Command Logic

This block sits between an external motor controller and the four gate drivers of a two-leg full bridge. Each leg has a high-side and a low-side command input. The block cleans up those commands and produces one gate-enable output per switch. It never lets both switches of a leg conduct together. If a leg is asked for both switches at once, or for neither, that leg is simply turned off. The block inserts no dead time; switching delays stay the job of the controller.

A global enable input turns every gate off at once. If enable stays low long enough, the block falls into a low-power sleep state in which every output is released to high impedance. When enable returns, a wake-up delay passes before the outputs are driven again. A separate disable input from the supply monitor also forces all gates off, but it never causes sleep. Each command input is synchronized to the clock and must hold a new level for several cycles before it is accepted. This rejects short glitches.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: With enable high, disable low and the block awake, a leg whose high command alone is set drives only its high gate (1). A leg whose low command alone is set drives only its low gate (1).
- R2: A leg whose two commands are both 1, or both 0, drives both of its gates to 0. At no time are both gates of one leg 1.
- R3: While enable_i is 0, every gate output is 0 in the same cycle, whatever the command inputs are.
- R4: While supply_dis_i is 1, every gate output is 0 in the same cycle. Holding it for longer than the sleep timeout does not set any high-impedance output.
- R5: Sleep is entered once enable_i has been 0 for SLEEP_CYCLES + SYNC_STAGES cycles, where SLEEP_CYCLES = CLK_FREQ_HZ/1e6 × SLEEP_TIMEOUT_US. All hiz outputs then read 1 and all gate outputs read 0.
- R6: After enable_i returns to 1 in sleep, the hiz outputs clear WAKE_CYCLES + SYNC_STAGES + 1 cycles later, where WAKE_CYCLES = CLK_FREQ_HZ/1e6 × WAKE_DELAY_US. From then on the gates follow the commands.
- R7: A low pulse on enable_i shorter than the timeout does not cause sleep, and the timeout restarts from zero on every return of enable high.
- R8: A command input pulse lasting fewer than FILT_CYCLES clock cycles has no effect on the gate outputs.
- R9: A command level held steady is reflected at the gate outputs exactly SYNC_STAGES + FILT_CYCLES cycles after the edge following its change.
- R10: Each leg is decoded from its own commands only. Bit p of every command and output vector belongs to leg p, for both the gates and the hiz outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Global enable; low turns gates off and, held, causes sleep |
| supply_dis_i | input | 1 | Supply-monitor disable; forces all gates off |
| cmd_hi_i | input | NUM_PHASES | High-side command per leg |
| cmd_lo_i | input | NUM_PHASES | Low-side command per leg |
| gate_hi_o | output | NUM_PHASES | High-side gate enable per leg |
| gate_lo_o | output | NUM_PHASES | Low-side gate enable per leg |
| hiz_hi_o | output | NUM_PHASES | High-impedance request for each high-side driver |
| hiz_lo_o | output | NUM_PHASES | High-impedance request for each low-side driver |

## Verification
A glitch filter whose counter fails to clear would show up at the gates as a command accepted early. The exact-latency check catches this within one filter window. A power sequencer counting off by one moves the edge of the hiz outputs by one cycle. For that reason the sleep and wake transitions are sampled at the cycle before and the cycle of the expected change. A decode fault, such as priority instead of lock-out, appears as soon as a conflicting command pair passes the filter. A stuck sleep or wake state appears as hiz outputs that never set or never clear.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_SLEEP  = 2'd1,
    PWR_WAKE   = 2'd2
  } pwr_state_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_pair_t;

  // Lock-out decode: a conflicting or empty request turns the leg off.
  function automatic leg_pair_t leg_decode(input logic hi_cmd, input logic lo_cmd);
    leg_pair_t r;
    r.hi = hi_cmd & ~lo_cmd;
    r.lo = lo_cmd & ~hi_cmd;
    return r;
  endfunction

endpackage

// File: rtl/hbg_level_filter.sv
module hbg_level_filter #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned STABLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o
);

  localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_bit;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   lvl_q, lvl_d;

  assign sync_bit = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  // A new level is taken only after it has differed from the held
  // level on STABLE_CYCLES consecutive edges.
  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (sync_bit != lvl_q) begin
      if (cnt_q == CW'(STABLE_CYCLES - 1)) begin
        lvl_d = sync_bit;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign level_o = lvl_q;

endmodule

// File: rtl/hbg_leg_interlock.sv
module hbg_leg_interlock
  import hbg_pkg::*;
#(
  parameter int unsigned NUM_PHASES = 2
) (
  input  logic [NUM_PHASES-1:0] hi_i,
  input  logic [NUM_PHASES-1:0] lo_i,
  input  logic                  run_i,
  output logic [NUM_PHASES-1:0] gate_hi_o,
  output logic [NUM_PHASES-1:0] gate_lo_o
);

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_leg
    leg_pair_t dec;
    always_comb begin
      dec          = leg_decode(hi_i[p], lo_i[p]);
      gate_hi_o[p] = dec.hi & run_i;
      gate_lo_o[p] = dec.lo & run_i;
    end
  end

endmodule

// File: rtl/hbg_power_seq.sv
module hbg_power_seq
  import hbg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned SLEEP_CYCLES = 1_000_000,
  parameter int unsigned WAKE_CYCLES  = 50_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  output logic active_o,
  output logic asleep_o
);

  localparam int unsigned MAX_CNT = (SLEEP_CYCLES > WAKE_CYCLES) ? SLEEP_CYCLES : WAKE_CYCLES;
  localparam int unsigned CW      = $clog2(MAX_CNT + 1);

  logic [SYNC_STAGES-1:0] en_sync_q;
  logic                   en_s;
  pwr_state_e             st_q, st_d;
  logic [CW-1:0]          cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_sync_q <= '0;
    else        en_sync_q <= {en_sync_q[SYNC_STAGES-2:0], enable_i};
  end

  assign en_s = en_sync_q[SYNC_STAGES-1];

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PWR_ACTIVE: begin
        if (en_s) begin
          cnt_d = '0;
        end else if (cnt_q == CW'(SLEEP_CYCLES - 1)) begin
          st_d  = PWR_SLEEP;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PWR_SLEEP: begin
        cnt_d = '0;
        if (en_s) st_d = PWR_WAKE;
      end
      PWR_WAKE: begin
        if (!en_s) begin
          st_d  = PWR_SLEEP;
          cnt_d = '0;
        end else if (cnt_q == CW'(WAKE_CYCLES - 1)) begin
          st_d  = PWR_ACTIVE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = PWR_SLEEP;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PWR_ACTIVE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign active_o = (st_q == PWR_ACTIVE);
  assign asleep_o = ~active_o;

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl #(
  parameter int unsigned NUM_PHASES       = 2,
  parameter int unsigned SYNC_STAGES      = 2,
  parameter int unsigned FILT_CYCLES      = 4,
  parameter int unsigned CLK_FREQ_HZ      = 100_000_000,
  parameter int unsigned SLEEP_TIMEOUT_US = 10_000,
  parameter int unsigned WAKE_DELAY_US    = 500
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable_i,
  input  logic                  supply_dis_i,
  input  logic [NUM_PHASES-1:0] cmd_hi_i,
  input  logic [NUM_PHASES-1:0] cmd_lo_i,
  output logic [NUM_PHASES-1:0] gate_hi_o,
  output logic [NUM_PHASES-1:0] gate_lo_o,
  output logic [NUM_PHASES-1:0] hiz_hi_o,
  output logic [NUM_PHASES-1:0] hiz_lo_o
);

  localparam int unsigned CYC_PER_US   = CLK_FREQ_HZ / 1_000_000;
  localparam int unsigned SLEEP_CYCLES = CYC_PER_US * SLEEP_TIMEOUT_US;
  localparam int unsigned WAKE_CYCLES  = CYC_PER_US * WAKE_DELAY_US;

  logic [NUM_PHASES-1:0] filt_hi, filt_lo;
  logic                  active, asleep, run;

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_filt
    hbg_level_filter #(
      .SYNC_STAGES  (SYNC_STAGES),
      .STABLE_CYCLES(FILT_CYCLES)
    ) u_hi (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (cmd_hi_i[p]),
      .level_o(filt_hi[p])
    );
    hbg_level_filter #(
      .SYNC_STAGES  (SYNC_STAGES),
      .STABLE_CYCLES(FILT_CYCLES)
    ) u_lo (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (cmd_lo_i[p]),
      .level_o(filt_lo[p])
    );
  end

  hbg_power_seq #(
    .SYNC_STAGES (SYNC_STAGES),
    .SLEEP_CYCLES(SLEEP_CYCLES),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) u_pwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable_i(enable_i),
    .active_o(active),
    .asleep_o(asleep)
  );

  // Raw enable and supply disable cut the gates without waiting for a clock.
  assign run = active & enable_i & ~supply_dis_i;

  hbg_leg_interlock #(
    .NUM_PHASES(NUM_PHASES)
  ) u_lock (
    .hi_i     (filt_hi),
    .lo_i     (filt_lo),
    .run_i    (run),
    .gate_hi_o(gate_hi_o),
    .gate_lo_o(gate_lo_o)
  );

  assign hiz_hi_o = {NUM_PHASES{asleep}};
  assign hiz_lo_o = {NUM_PHASES{asleep}};

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
  parameter int unsigned NUM_PHASES = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  enable_i,
  input logic                  supply_dis_i,
  input logic [NUM_PHASES-1:0] gate_hi_o,
  input logic [NUM_PHASES-1:0] gate_lo_o,
  input logic [NUM_PHASES-1:0] hiz_hi_o,
  input logic [NUM_PHASES-1:0] hiz_lo_o
);

  assert_leg_lockout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi_o & gate_lo_o) == '0);

  assert_enable_cut_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |-> (gate_hi_o == '0 && gate_lo_o == '0));

  assert_supply_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    supply_dis_i |-> (gate_hi_o == '0 && gate_lo_o == '0));

  assert_sleep_gates_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_hi_o != '0) |-> (gate_hi_o == '0 && gate_lo_o == '0));

  assert_hiz_uniform_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_hi_o == hiz_lo_o) && ($countones(hiz_hi_o) == 0 || $countones(hiz_hi_o) == NUM_PHASES));

  assert_wake_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hiz_hi_o[0]) |-> $past(enable_i));

endmodule

bind hbridge_gate_ctrl hbg_checker #(.NUM_PHASES(NUM_PHASES)) u_hbg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable_i    (enable_i),
  .supply_dis_i(supply_dis_i),
  .gate_hi_o   (gate_hi_o),
  .gate_lo_o   (gate_lo_o),
  .hiz_hi_o    (hiz_hi_o),
  .hiz_lo_o    (hiz_lo_o)
);

// File: tb/tb_hbridge_gate_ctrl.sv
`timescale 1ns/1ps
module tb_hbridge_gate_ctrl;

  localparam int CLK_PERIOD = 1000;
  localparam int NPH        = 2;
  localparam int SYNC       = 2;
  localparam int FILT       = 4;
  localparam int SLEEP      = 300;
  localparam int WAKE       = 40;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           enable_i;
  logic           supply_dis_i;
  logic [NPH-1:0] cmd_hi_i, cmd_lo_i;
  logic [NPH-1:0] gate_hi_o, gate_lo_o, hiz_hi_o, hiz_lo_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_gate_ctrl #(
    .NUM_PHASES      (NPH),
    .SYNC_STAGES     (SYNC),
    .FILT_CYCLES     (FILT),
    .CLK_FREQ_HZ     (1_000_000),
    .SLEEP_TIMEOUT_US(SLEEP),
    .WAKE_DELAY_US   (WAKE)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .supply_dis_i(supply_dis_i),
    .cmd_hi_i    (cmd_hi_i),
    .cmd_lo_i    (cmd_lo_i),
    .gate_hi_o   (gate_hi_o),
    .gate_lo_o   (gate_lo_o),
    .hiz_hi_o    (hiz_hi_o),
    .hiz_lo_o    (hiz_lo_o)
  );

  // Expected {gate_hi, gate_lo} from settled commands and the run condition.
  function automatic logic [2*NPH-1:0] exp_gates(logic [NPH-1:0] hi, logic [NPH-1:0] lo, logic run);
    logic [NPH-1:0] eh, el;
    for (int p = 0; p < NPH; p++) begin
      eh[p] = run & hi[p] & ~lo[p];
      el[p] = run & lo[p] & ~hi[p];
    end
    return {eh, el};
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [2*NPH-1:0] act, logic [2*NPH-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_cmd(logic [NPH-1:0] hi, logic [NPH-1:0] lo);
    cmd_hi_i = hi;
    cmd_lo_i = lo;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [NPH-1:0] rh, rl;
    logic           rd;
    void'($urandom(32'd4242));
    rst_n = 1'b0; enable_i = 1'b1; supply_dis_i = 1'b0;
    set_cmd('0, '0);
    step(3);
    check("reset gates", {gate_hi_o, gate_lo_o}, '0);
    check("reset hiz", {hiz_hi_o, hiz_lo_o}, '0);
    rst_n = 1'b1;
    step(2);

    // R1 / R9: exact latency of an accepted command, leg 0 high, leg 1 low
    set_cmd(2'b01, 2'b10);
    step(SYNC + FILT - 1);
    check("R9 before latency", {gate_hi_o, gate_lo_o}, '0);
    step(1);
    check("R9 at latency", {gate_hi_o, gate_lo_o}, exp_gates(2'b01, 2'b10, 1'b1));
    check("R1 single commands", {gate_hi_o, gate_lo_o}, 4'b0110);
    check("R10 leg mapping", {gate_hi_o, gate_lo_o}, {2'b01, 2'b10});

    // R2: both set on leg 0, both clear on leg 1
    set_cmd(2'b01, 2'b01);
    step(SYNC + FILT + 2);
    check("R2 conflict off", {gate_hi_o, gate_lo_o}, '0);

    // R8: short glitch ignored
    set_cmd(2'b10, 2'b00);
    step(SYNC + FILT + 2);
    check("R8 baseline", {gate_hi_o, gate_lo_o}, 4'b1000);
    cmd_lo_i[1] = 1'b1;
    step(FILT - 1);
    cmd_lo_i[1] = 1'b0;
    step(SYNC + FILT + 2);
    check("R8 glitch rejected", {gate_hi_o, gate_lo_o}, 4'b1000);
    cmd_hi_i[1] = 1'b0;
    step(1);
    cmd_hi_i[1] = 1'b1;
    step(SYNC + FILT + 2);
    check("R8 dropout rejected", {gate_hi_o, gate_lo_o}, 4'b1000);

    // R3: enable low cuts immediately
    enable_i = 1'b0;
    #1;
    check("R3 immediate cut", {gate_hi_o, gate_lo_o}, '0);
    step(20);
    check("R3 held cut", {gate_hi_o, gate_lo_o}, '0);
    enable_i = 1'b1;
    step(SLEEP - 10);
    // R7: two sub-timeout gaps; the count must restart between them
    enable_i = 1'b0;
    step(SLEEP - 10);
    enable_i = 1'b1;
    step(5);
    enable_i = 1'b0;
    step(SLEEP - 10);
    check("R7 no sleep", {hiz_hi_o, hiz_lo_o}, '0);
    enable_i = 1'b1;
    step(3);
    check("R7 gates restored", {gate_hi_o, gate_lo_o}, 4'b1000);

    // R4: supply disable, long hold, no sleep
    supply_dis_i = 1'b1;
    #1;
    check("R4 immediate cut", {gate_hi_o, gate_lo_o}, '0);
    step(SLEEP + 20);
    check("R4 no hiz", {hiz_hi_o, hiz_lo_o}, '0);
    check("R4 held cut", {gate_hi_o, gate_lo_o}, '0);
    supply_dis_i = 1'b0;
    step(1);
    check("R4 release", {gate_hi_o, gate_lo_o}, 4'b1000);

    // R5: sleep entry at an exact cycle
    enable_i = 1'b0;
    step(SLEEP + SYNC - 1);
    check("R5 before sleep", {hiz_hi_o, hiz_lo_o}, '0);
    step(1);
    check("R5 asleep hiz", {hiz_hi_o, hiz_lo_o}, '1);
    check("R5 asleep gates", {gate_hi_o, gate_lo_o}, '0);

    // R6: wake at an exact cycle, new commands followed
    set_cmd(2'b00, 2'b11);
    step(10);
    enable_i = 1'b1;
    step(WAKE + SYNC);
    check("R6 still waking", {hiz_hi_o, hiz_lo_o}, '1);
    check("R6 gates off waking", {gate_hi_o, gate_lo_o}, '0);
    step(1);
    check("R6 awake hiz", {hiz_hi_o, hiz_lo_o}, '0);
    check("R6 follows commands", {gate_hi_o, gate_lo_o}, 4'b0011);

    // R1 / R2 / R10 / R4: random command patterns
    for (int i = 0; i < 150; i++) begin
      rh = NPH'($urandom);
      rl = NPH'($urandom);
      rd = ($urandom % 5) == 0;
      set_cmd(rh, rl);
      supply_dis_i = rd;
      step(SYNC + FILT + 1);
      check("R1/R2/R10 random", {gate_hi_o, gate_lo_o}, exp_gates(rh, rl, ~rd));
    end
    supply_dis_i = 1'b0;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule